// File: doc/BRIEF.md
# DS1-to-E1 Timeslot Rate Mapper

This block places the payload bytes of one framed 24-slot DS1 stream into a 32-slot system frame running at 2.048 Mbit/s. It also has a direct mode for E1 lines, in which every line slot lands in the system slot with the same number. The line side writes bytes into a one-frame slot store. Each byte carries its line slot index and a marker for the start of the frame. The system side steps through system slots with a slot strobe. For each slot it outputs the slot number, a byte, and a flag that marks filler slots. In DS1 mode eight system slots in each frame carry no payload. Those slots carry a programmable fill byte instead. A 3-bit placement code sets where the filler slots go.

Mode, placement code and fill byte are sampled only when the system slot counter is at slot 0. A configuration change therefore never splits a system frame. The same sampled mode also decides which line writes the store accepts. Line framing recovery, clock-domain crossing and serialization are outside this block. The line side and the system side share one clock.

Top module: `ds1_e1_slot_mapper`

## Requirements
- R1: After reset, sys_valid, sys_stuff, sys_slot and sys_byte are all zero. The mode in force is DS1, with placement code 0 and fill byte 0xFF. Every store entry holds 0x00.
- R2: Each cycle with sys_en high emits one system slot. In the next cycle sys_valid is high and sys_slot shows the counter value. The counter then advances by one and wraps from 31 to 0. In a cycle after one with sys_en low, sys_valid is low.
- R3: DS1 with placement code 0: system slot s is a filler slot when s mod 4 = 0. Any other slot carries line slot s − floor(s/4) − 1.
- R4: DS1 with placement code 1: system slots 24..31 are filler slots. System slot s < 24 carries line slot s.
- R5: DS1 with placement code 2: system slots 0..7 are filler slots. System slot s ≥ 8 carries line slot s − 8.
- R6: DS1 with placement codes 3 through 7 behaves exactly like code 0.
- R7: E1 mode (cfg_e1_mode = 1): system slot n carries line slot n for all 32 slots, and no slot is a filler slot. This includes the framing byte in slot 0.
- R8: A filler slot drives sys_stuff = 1, and sys_byte equals the fill byte sampled for that frame. A payload slot drives sys_stuff = 0.
- R9: Mode, placement code and fill byte are sampled in the cycle where sys_en is high and the counter is at 0. That cycle's output already uses the new values. Changes at any other time take effect only at the next frame.
- R10: When ln_valid is high, ln_byte is stored for line slot ln_slot, but only if two conditions hold. First, ln_fstart must be high exactly when ln_slot is 0. Second, the mode in force must be E1, or ln_slot must be below 24. Any other write leaves the store unchanged.
- R11: A line write and a system read of the same store entry can fall in the same cycle. In that case the system output carries the previous content, and the new byte appears from the next read onward.
- R12: In every DS1 frame exactly 8 slots are filler slots. Each of the 24 stored payload bytes appears exactly once, in line slot order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by line and system sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_e1_mode | input | 1 | 1 selects one-to-one E1 mapping, 0 selects DS1 adaptation |
| cfg_fill_pat | input | 3 | Filler slot placement code for DS1 mode |
| cfg_fill_byte | input | 8 | Byte sent in filler slots |
| ln_valid | input | 1 | Line byte write strobe |
| ln_fstart | input | 1 | Marks the first slot (slot 0) of a line frame |
| ln_slot | input | 5 | Line slot index of ln_byte |
| ln_byte | input | 8 | Line payload byte |
| sys_en | input | 1 | System slot strobe, one slot per high cycle |
| sys_valid | output | 1 | Output slot valid, one cycle after sys_en |
| sys_slot | output | 5 | System slot index of the output byte |
| sys_byte | output | 8 | Output byte (payload or fill) |
| sys_stuff | output | 1 | High for a filler slot |

## Verification
Two functions can fall in the same cycle. A line write can hit the store entry that the system side is reading in that cycle. The bench provokes this by writing, alongside the strobe, the line slot that the current system slot maps to. It expects the old byte at once and the new byte one frame later. The second overlap is the frame-start cycle, where a new configuration is sampled and slot 0 is emitted under it. The bench changes mode, code and fill just before slot 0 and again in the middle of a frame. Its model decides which setting must govern each emitted slot.

// File: rtl/rm_pkg.sv
package rm_pkg;
  // Frame geometry
  parameter int SYS_SLOTS      = 32;
  parameter int DS1_PAY_SLOTS  = 24;
  parameter int BYTE_W         = 8;
  parameter int PAT_W          = 3;

  localparam int SLOT_W     = $clog2(SYS_SLOTS);
  localparam int FILL_SLOTS = SYS_SLOTS - DS1_PAY_SLOTS;
  localparam int GROUP      = SYS_SLOTS / FILL_SLOTS;
  localparam int GRP_SH     = $clog2(GROUP);

  typedef struct packed {
    logic              e1;
    logic [PAT_W-1:0]  pat;
    logic [BYTE_W-1:0] fill;
  } rm_cfg_t;

  typedef enum logic [1:0] {
    PL_SPREAD = 2'd0,
    PL_TAIL   = 2'd1,
    PL_HEAD   = 2'd2
  } place_e;
endpackage

// File: rtl/rm_cfg_hold.sv
module rm_cfg_hold
  import rm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv,
  input  logic    frame_start,
  input  rm_cfg_t cfg_live,
  output rm_cfg_t cfg_use,
  output rm_cfg_t cfg_held
);
  logic hold_en;

  always_comb begin
    cfg_use = frame_start ? cfg_live : cfg_held;
    hold_en = adv & frame_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_held <= {1'b0, {PAT_W{1'b0}}, {BYTE_W{1'b1}}};
    end else if (hold_en) begin
      cfg_held <= cfg_use;
    end
  end
endmodule

// File: rtl/rm_slot_xlate.sv
module rm_slot_xlate
  import rm_pkg::*;
(
  input  logic              e1,
  input  logic [PAT_W-1:0]  pat,
  input  logic [SLOT_W-1:0] sys_slot,
  output logic              stuff,
  output logic [SLOT_W-1:0] line_idx
);
  localparam logic [SLOT_W-1:0] PAY_LIM  = SLOT_W'(DS1_PAY_SLOTS);
  localparam logic [SLOT_W-1:0] FILL_LIM = SLOT_W'(FILL_SLOTS);

  place_e            place;
  logic [SLOT_W-1:0] grp_no;
  logic [GRP_SH-1:0] in_grp;

  always_comb begin
    unique case (pat)
      PAT_W'(1): place = PL_TAIL;
      PAT_W'(2): place = PL_HEAD;
      default:   place = PL_SPREAD;
    endcase
    grp_no = sys_slot >> GRP_SH;
    in_grp = sys_slot[GRP_SH-1:0];
  end

  always_comb begin
    if (e1) begin
      stuff    = 1'b0;
      line_idx = sys_slot;
    end else begin
      unique case (place)
        PL_TAIL: begin
          stuff    = (sys_slot >= PAY_LIM);
          line_idx = sys_slot;
        end
        PL_HEAD: begin
          stuff    = (sys_slot < FILL_LIM);
          line_idx = sys_slot - FILL_LIM;
        end
        default: begin
          stuff    = (in_grp == '0);
          line_idx = sys_slot - grp_no - SLOT_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/rm_line_store.sv
module rm_line_store
  import rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0]    mem [SYS_SLOTS];
  logic [SYS_SLOTS-1:0] we;

  for (genvar g = 0; g < SYS_SLOTS; g++) begin : g_we
    assign we[g] = wr_en & (wr_idx == SLOT_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYS_SLOTS; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < SYS_SLOTS; i++) begin
        if (we[i]) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/ds1_e1_slot_mapper.sv
module ds1_e1_slot_mapper
  import rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_e1_mode,
  input  logic [PAT_W-1:0]  cfg_fill_pat,
  input  logic [BYTE_W-1:0] cfg_fill_byte,
  input  logic              ln_valid,
  input  logic              ln_fstart,
  input  logic [SLOT_W-1:0] ln_slot,
  input  logic [BYTE_W-1:0] ln_byte,
  input  logic              sys_en,
  output logic              sys_valid,
  output logic [SLOT_W-1:0] sys_slot,
  output logic [BYTE_W-1:0] sys_byte,
  output logic              sys_stuff
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SYS_SLOTS - 1);
  localparam logic [SLOT_W-1:0] PAY_LIM   = SLOT_W'(DS1_PAY_SLOTS);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // System slot counter
  logic [SLOT_W-1:0] slot_cnt, slot_cnt_d;
  logic              frame_start;

  always_comb begin
    frame_start = (slot_cnt == '0);
    slot_cnt_d  = (slot_cnt == LAST_SLOT) ? '0 : slot_cnt + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  slot_cnt <= '0;
    else if (sys_en)  slot_cnt <= slot_cnt_d;
  end

  // Configuration sampled at frame boundary
  rm_cfg_t cfg_live, cfg_use, cfg_held;
  assign cfg_live = {cfg_e1_mode, cfg_fill_pat, cfg_fill_byte};

  rm_cfg_hold u_cfg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .adv         (sys_en),
    .frame_start (frame_start),
    .cfg_live    (cfg_live),
    .cfg_use     (cfg_use),
    .cfg_held    (cfg_held)
  );

  // Slot translation
  logic              map_stuff;
  logic [SLOT_W-1:0] map_idx;

  rm_slot_xlate u_xlate (
    .e1       (cfg_use.e1),
    .pat      (cfg_use.pat),
    .sys_slot (slot_cnt),
    .stuff    (map_stuff),
    .line_idx (map_idx)
  );

  // Line-side write qualification and store
  logic              wr_ok;
  logic [BYTE_W-1:0] rd_byte;

  always_comb begin
    wr_ok = ln_valid
          & (ln_fstart == (ln_slot == '0))
          & (cfg_held.e1 | (ln_slot < PAY_LIM));
  end

  rm_line_store u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_ok),
    .wr_idx  (ln_slot),
    .wr_data (ln_byte),
    .rd_idx  (map_idx),
    .rd_data (rd_byte)
  );

  // Output stage
  logic [BYTE_W-1:0] out_byte_d;

  always_comb begin
    out_byte_d = map_stuff ? cfg_use.fill : rd_byte;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sys_valid <= 1'b0;
    end else begin
      sys_valid <= sys_en;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sys_slot  <= '0;
      sys_byte  <= '0;
      sys_stuff <= 1'b0;
    end else if (sys_en) begin
      sys_slot  <= slot_cnt;
      sys_byte  <= out_byte_d;
      sys_stuff <= map_stuff;
    end
  end
endmodule

// File: rtl/ds1_e1_slot_mapper_chk.sv
module ds1_e1_slot_mapper_chk
  import rm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sys_en,
  input logic [SLOT_W-1:0] cnt,
  input rm_cfg_t           held,
  input logic              sys_valid,
  input logic [SLOT_W-1:0] sys_slot,
  input logic [BYTE_W-1:0] sys_byte,
  input logic              sys_stuff
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SYS_SLOTS - 1);
  localparam logic [SLOT_W-1:0] PAY_LIM   = SLOT_W'(DS1_PAY_SLOTS);

  logic [SLOT_W:0] fill_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else if (sys_valid) begin
      if (sys_slot == '0) fill_cnt <= (SLOT_W+1)'(sys_stuff);
      else                fill_cnt <= fill_cnt + (SLOT_W+1)'(sys_stuff);
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_en |=> sys_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_en |=> !sys_valid);

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_en && sys_valid) |=> (sys_slot == SLOT_W'($past(sys_slot) + SLOT_W'(1))));

  p_pat1_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_valid && !held.e1 && held.pat == PAT_W'(1)) |-> (sys_stuff == (sys_slot >= PAY_LIM)));

  p_e1_nofill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_valid && held.e1) |-> !sys_stuff);

  p_fill_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_valid && sys_stuff) |-> (sys_byte == held.fill));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_en && cnt == '0) |=> $stable(held));

  p_eight_fill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_valid && sys_slot == LAST_SLOT && !held.e1)
      |-> ((fill_cnt + (SLOT_W+1)'(sys_stuff)) == (SLOT_W+1)'(FILL_SLOTS)));
endmodule

bind ds1_e1_slot_mapper ds1_e1_slot_mapper_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sys_en    (sys_en),
  .cnt       (slot_cnt),
  .held      (cfg_held),
  .sys_valid (sys_valid),
  .sys_slot  (sys_slot),
  .sys_byte  (sys_byte),
  .sys_stuff (sys_stuff)
);

// File: tb/ds1_e1_slot_mapper_bench.sv
module ds1_e1_slot_mapper_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_e1_mode;
  logic [2:0] cfg_fill_pat;
  logic [7:0] cfg_fill_byte;
  logic       ln_valid, ln_fstart;
  logic [4:0] ln_slot;
  logic [7:0] ln_byte;
  logic       sys_en;
  logic       sys_valid;
  logic [4:0] sys_slot;
  logic [7:0] sys_byte;
  logic       sys_stuff;

  always #10 clk = ~clk;

  ds1_e1_slot_mapper u_ds1_e1_slot_mapper (
    .clk(clk), .rst_n(rst_n), .cfg_e1_mode(cfg_e1_mode), .cfg_fill_pat(cfg_fill_pat),
    .cfg_fill_byte(cfg_fill_byte), .ln_valid(ln_valid), .ln_fstart(ln_fstart),
    .ln_slot(ln_slot), .ln_byte(ln_byte), .sys_en(sys_en), .sys_valid(sys_valid),
    .sys_slot(sys_slot), .sys_byte(sys_byte), .sys_stuff(sys_stuff)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench model
  bit [7:0] mdl_buf [32];
  bit [7:0] snap [32];
  bit [7:0] got_pay [32];
  int       got_n;
  int       b_cnt;
  bit       h_e1;
  bit [2:0] h_pat;
  bit [7:0] h_fill;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void bmap(input bit e1, input bit [2:0] pat, input int s,
                               output bit st, output int li);
    if (e1) begin
      st = 1'b0; li = s;
    end else if (pat == 3'd1) begin
      st = (s >= 24); li = s;
    end else if (pat == 3'd2) begin
      st = (s < 8); li = s - 8;
    end else begin
      st = ((s % 4) == 0); li = s - (s / 4) - 1;
    end
  endfunction

  task automatic step(input bit do_w, input int ws, input bit [7:0] wb, input bit wfs,
                      input bit do_s, input string tag);
    bit u_e1; bit [2:0] u_pat; bit [7:0] u_fill;
    bit st; int li; bit [7:0] eb; bit acc; string rq;
    ln_valid = do_w; ln_slot = ws[4:0]; ln_byte = wb; ln_fstart = wfs; sys_en = do_s;
    if (b_cnt == 0) begin
      u_e1 = cfg_e1_mode; u_pat = cfg_fill_pat; u_fill = cfg_fill_byte;
    end else begin
      u_e1 = h_e1; u_pat = h_pat; u_fill = h_fill;
    end
    bmap(u_e1, u_pat, b_cnt, st, li);
    eb  = st ? u_fill : mdl_buf[li];
    acc = do_w && (wfs == (ws == 0)) && (h_e1 || ws < 24);
    @(posedge clk);
    @(negedge clk);
    if (do_s) begin
      if (tag != "")            rq = tag;
      else if (u_e1)            rq = "R7";
      else if (st)              rq = "R8";
      else if (u_pat == 3'd1)   rq = "R4";
      else if (u_pat == 3'd2)   rq = "R5";
      else if (u_pat == 3'd0)   rq = "R3";
      else                      rq = "R6";
      check(sys_valid === 1'b1, "R2", "valid", int'(sys_valid), 1);
      check(sys_slot === b_cnt[4:0], "R2", "slot", int'(sys_slot), b_cnt);
      check(sys_stuff === st, rq, "stuff", int'(sys_stuff), int'(st));
      check(sys_byte === eb, rq, "byte", int'(sys_byte), int'(eb));
      if (b_cnt == 0) begin
        h_e1 = u_e1; h_pat = u_pat; h_fill = u_fill; got_n = 0;
      end
      if (!sys_stuff && got_n < 32) begin
        got_pay[got_n] = sys_byte; got_n++;
      end
      b_cnt = (b_cnt + 1) % 32;
    end else begin
      check(sys_valid === 1'b0, "R2", "idle valid", int'(sys_valid), 0);
    end
    if (acc) mdl_buf[ws] = wb;
    ln_valid = 1'b0; sys_en = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 32; i++) step(1'b1, i, 8'($urandom), i == 0, 1'b0, "R10");
  endtask

  task automatic run_frame(input string tag, input bit mid_change);
    for (int i = 0; i < 32; i++) snap[i] = mdl_buf[i];
    for (int k = 0; k < 32; k++) begin
      if (($urandom % 5) == 0) step(1'b0, 0, 8'h00, 1'b0, 1'b0, "");
      if (mid_change && k == 3) begin
        cfg_e1_mode = ~cfg_e1_mode; cfg_fill_pat = 3'($urandom); cfg_fill_byte = 8'($urandom);
      end
      step(1'b0, 0, 8'h00, 1'b0, 1'b1, tag);
    end
    if (!h_e1) begin
      check(got_n == 24, "R12", "payload count", got_n, 24);
      for (int i = 0; i < 24; i++)
        check(got_pay[i] == snap[i], "R12", "payload order", int'(got_pay[i]), int'(snap[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; cfg_e1_mode = 1'b0; cfg_fill_pat = 3'd0; cfg_fill_byte = 8'hFF;
    ln_valid = 1'b0; ln_fstart = 1'b0; ln_slot = '0; ln_byte = '0; sys_en = 1'b0;
    for (int i = 0; i < 32; i++) mdl_buf[i] = 8'h00;
    b_cnt = 0; h_e1 = 1'b0; h_pat = 3'd0; h_fill = 8'hFF; got_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(sys_valid === 1'b0, "R1", "valid", int'(sys_valid), 0);
    check(sys_stuff === 1'b0, "R1", "stuff", int'(sys_stuff), 0);
    check(sys_slot === 5'd0, "R1", "slot", int'(sys_slot), 0);
    check(sys_byte === 8'd0, "R1", "byte", int'(sys_byte), 0);

    // Load in DS1 (slots 24..31 rejected, R10), then every placement code (R3..R6, R12)
    load_all();
    for (int c = 0; c < 8; c++) begin
      cfg_e1_mode = 1'b0; cfg_fill_pat = 3'(c); cfg_fill_byte = 8'($urandom);
      run_frame("", 1'b0);
      load_all();
    end

    // R9: config change inside a frame waits for the next boundary
    cfg_e1_mode = 1'b0; cfg_fill_pat = 3'd1; cfg_fill_byte = 8'hC3;
    run_frame("R9", 1'b1);
    cfg_e1_mode = 1'b0; cfg_fill_pat = 3'd2; cfg_fill_byte = 8'h3C;
    run_frame("R9", 1'b0);

    // R7: E1 mode, then full load now accepted for all 32 slots (R10)
    cfg_e1_mode = 1'b1;
    run_frame("", 1'b0);
    load_all();
    run_frame("R7", 1'b0);

    // R10: misaligned frame-start marker is ignored
    step(1'b1, 5, 8'hA5, 1'b1, 1'b0, "R10");
    step(1'b1, 0, 8'h5A, 1'b0, 1'b0, "R10");
    run_frame("R10", 1'b0);

    // R10: DS1 frame rejects a write to slot 28; E1 frame shows the old byte
    cfg_e1_mode = 1'b0; cfg_fill_pat = 3'd1;
    step(1'b0, 0, 8'h00, 1'b0, 1'b1, "");
    step(1'b1, 28, 8'h99, 1'b0, 1'b0, "R10");
    for (int k = 1; k < 32; k++) step(1'b0, 0, 8'h00, 1'b0, 1'b1, "");
    cfg_e1_mode = 1'b1;
    run_frame("R10", 1'b0);

    // R11: write and read of the same entry in one cycle
    cfg_e1_mode = 1'b0; cfg_fill_pat = 3'd1;
    for (int k = 0; k < 32; k++) begin
      if (k == 10) step(1'b1, 10, 8'($urandom), 1'b0, 1'b1, "R11");
      else         step(1'b0, 0, 8'h00, 1'b0, 1'b1, "");
    end
    run_frame("R11", 1'b0);
    cfg_fill_pat = 3'd0;
    for (int k = 0; k < 32; k++) begin
      if (k == 13) step(1'b1, 9, 8'($urandom), 1'b0, 1'b1, "R11");
      else         step(1'b0, 0, 8'h00, 1'b0, 1'b1, "");
    end

    // Random mix of writes, strobes and config changes
    for (int n = 0; n < 4000; n++) begin
      int ws;
      ws = int'($urandom % 32);
      if (($urandom % 40) == 0) begin
        cfg_e1_mode = 1'($urandom); cfg_fill_pat = 3'($urandom); cfg_fill_byte = 8'($urandom);
      end
      step(1'($urandom), ws, 8'($urandom), (ws == 0) ^ (($urandom % 16) == 0),
           ($urandom % 4) != 0, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule